// File: doc/BRIEF.md
# Half-Word Write-Masked GPIO Register Bank

This block holds the configuration state of a 32-pin general-purpose I/O port and presents it on a simple synchronous bus. Each 32-bit logical register takes two adjacent bus words. The low 16 pins sit at the base address and the high 16 pins sit at base+4. On a write, the upper half of the bus word is a per-bit enable for the lower half. Software can therefore set or clear any single pin bit in one write, with no read-modify-write sequence and no lock.

The stored configuration drives the rest of the controller on dedicated outputs:

- output value
- direction
- interrupt enable, mask, type, polarity and both-edge selection
- debounce enable and divided-debounce enable
- a 24-bit debounce divider

The bank also reads back three live inputs: interrupt status, raw interrupt status and the external pin levels. It returns a fixed version word, and turns an end-of-interrupt write into a one-cycle acknowledge pulse per pin.

Top module: `gpio_wm_regs`

## Requirements
- R1: Bus bits 6:3 select the logical register and bus bit 2 selects its half: pins 15:0 at the base offset, pins 31:16 at base+4. Bus bits 1:0 are ignored. The base offsets are:
  - 0x00 output value
  - 0x08 direction (1 = output, 0 = input)
  - 0x10 interrupt enable
  - 0x18 interrupt mask
  - 0x20 interrupt type
  - 0x28 polarity
  - 0x30 both-edge
  - 0x38 debounce enable
  - 0x40 divided-debounce enable
  - 0x48 divider
  - 0x50 status
  - 0x58 raw status
  - 0x60 end-of-interrupt
  - 0x70 pin levels
  - 0x78 version
- R2: On a write to a masked register half, bus bit 16+i enables bus bit i. A stored bit takes the data bit where its enable is 1 and keeps its value where its enable is 0. A write with all enables at 0 changes nothing.
- R3: While reset is asserted, every configuration output, the divider, the acknowledge pulse and the read data are zero.
- R4: Read data is registered. It appears the cycle after a read strobe and holds until the next read. For a masked register, the 16 selected bits are in bits 15:0 and bits 31:16 are zero. A write in the same cycle as a read does not affect that read's data.
- R5: A write to 0x48 loads bus bits 23:0 into the divider with no masking. A read of 0x48 returns the 24-bit divider, zero-extended, and 0x4C reads zero.
- R6: A read of 0x78 returns 0x00000C2B and a read of 0x7C returns 0x00000100. Together they form the version 0x01000C2B.
- R7: Status, raw status and pin-level registers return the live input halves. Writes to these registers and to the version registers change no state.
- R8: A write to 0x60 or 0x64 drives the acknowledge output, one cycle after the write, with a 1 on each pin whose data and enable bits are both 1. The output is zero in every other cycle, and reads of 0x60 and 0x64 return zero.
- R9: Writes to the divider's upper word at 0x4C and to the unmapped words 0x68 and 0x6C change no state. Reads of the unmapped words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data: enables in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Registered read data |
| irq_status_in | input | 32 | Live masked interrupt status |
| irq_raw_in | input | 32 | Live raw interrupt status |
| pin_in | input | 32 | Live external pin levels |
| out_val | output | 32 | Output value per pin |
| out_dir | output | 32 | Direction per pin, 1 = output |
| irq_en | output | 32 | Interrupt enable |
| irq_mask | output | 32 | Interrupt mask |
| irq_type | output | 32 | Interrupt type (edge/level) |
| irq_pol | output | 32 | Interrupt polarity |
| irq_both | output | 32 | Both-edge select |
| dbc_en | output | 32 | Debounce enable |
| dbc_div_en | output | 32 | Divided debounce clock enable |
| dbc_div | output | 24 | Debounce divider |
| eoi_pulse | output | 32 | One-cycle end-of-interrupt acknowledge |

## Verification
The bench targets the following faults:

- **Half selection.** A write meant for pins 31:16 lands on pins 15:0, or the reverse. This shows on the outputs as the wrong pins moving.
- **Mask handling.** A write with cleared enables clobbers neighbouring bits. A partial enable loses the bits it did not name. Both faults break the reference model on the very next cycle.
- **Divider.** A masked divider write would load only 16 bits.
- **Same-cycle read and write.** A read issued together with a write must return the value from before the write.
- **Read-only and unmapped words.** A block that let writes through would alter a later readback or an output.
- **Acknowledge pulse.** A pulse that lingers, or fires on the wrong half, mismatches the per-cycle expectation.

// File: rtl/gpio_wm_pkg.sv
package gpio_wm_pkg;
  // Logical register indices (bus address bits 6:3)
  localparam int IDX_DOUT  = 0;
  localparam int IDX_DIR   = 1;
  localparam int IDX_IEN   = 2;
  localparam int IDX_IMSK  = 3;
  localparam int IDX_ITYP  = 4;
  localparam int IDX_IPOL  = 5;
  localparam int IDX_IBOTH = 6;
  localparam int IDX_DBEN  = 7;
  localparam int IDX_DBDEN = 8;
  localparam int NUM_CFG   = 9;   // masked registers occupy indices 0..NUM_CFG-1
  localparam int IDX_DIV   = 9;
  localparam int IDX_STAT  = 10;
  localparam int IDX_RAW   = 11;
  localparam int IDX_EOI   = 12;
  localparam int IDX_PINS  = 14;
  localparam int IDX_VER   = 15;

  localparam logic [31:0] VERSION_WORD = 32'h0100_0C2B;
endpackage

// File: rtl/gpio_wm_rst_sync.sv
module gpio_wm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_wm_masked_reg.sv
module gpio_wm_masked_reg #(
  parameter int HALF_W = 16,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [FULL_W-1:0] wdata,
  output logic [FULL_W-1:0] q
);
  logic [HALF_W-1:0] dat, ena;
  logic [FULL_W-1:0] q_d;
  logic              upd;

  assign dat = wdata[HALF_W-1:0];
  assign ena = wdata[FULL_W-1:HALF_W];
  assign upd = wr_lo | wr_hi;

  always_comb begin
    q_d = q;
    if (wr_lo) q_d[HALF_W-1:0]      = (q[HALF_W-1:0] & ~ena) | (dat & ena);
    if (wr_hi) q_d[FULL_W-1:HALF_W] = (q[FULL_W-1:HALF_W] & ~ena) | (dat & ena);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_d;
  end

  // R2: unenabled bits of the low half keep their value
  assert_lo_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (((q[HALF_W-1:0] ^ $past(q[HALF_W-1:0])) & ~$past(ena)) == '0));
  // R2: unenabled bits of the high half keep their value
  assert_hi_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (((q[FULL_W-1:HALF_W] ^ $past(q[FULL_W-1:HALF_W])) & ~$past(ena)) == '0));
  // R2: no write, no change
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi) |=> $stable(q));
endmodule

// File: rtl/gpio_wm_rd_mux.sv
module gpio_wm_rd_mux
  import gpio_wm_pkg::*;
#(
  parameter int PIN_W = 32,
  parameter int DIV_W = 24,
  parameter int IDX_W = 4,
  localparam int HALF_W = PIN_W / 2
) (
  input  logic [IDX_W-1:0]              sel,
  input  logic                          hi,
  input  logic [NUM_CFG-1:0][PIN_W-1:0] cfg,
  input  logic [DIV_W-1:0]              div,
  input  logic [PIN_W-1:0]              stat,
  input  logic [PIN_W-1:0]              raw,
  input  logic [PIN_W-1:0]              pins,
  output logic [PIN_W-1:0]              word
);
  logic [PIN_W-1:0] logical;
  logic             is_div;

  always_comb begin
    logical = '0;
    is_div  = 1'b0;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (sel == IDX_W'(i)) logical = cfg[i];
    end
    if (sel == IDX_W'(IDX_STAT)) logical = stat;
    if (sel == IDX_W'(IDX_RAW))  logical = raw;
    if (sel == IDX_W'(IDX_PINS)) logical = pins;
    if (sel == IDX_W'(IDX_VER))  logical = PIN_W'(VERSION_WORD);
    if (sel == IDX_W'(IDX_DIV))  is_div  = 1'b1;
  end

  always_comb begin
    if (is_div)  word = hi ? '0 : PIN_W'(div);
    else if (hi) word = {{HALF_W{1'b0}}, logical[PIN_W-1:HALF_W]};
    else         word = {{HALF_W{1'b0}}, logical[HALF_W-1:0]};
  end
endmodule

// File: rtl/gpio_wm_regs.sv
module gpio_wm_regs
  import gpio_wm_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 7,
  parameter int DIV_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  irq_status_in,
  input  logic [PIN_W-1:0]  irq_raw_in,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  out_val,
  output logic [PIN_W-1:0]  out_dir,
  output logic [PIN_W-1:0]  irq_en,
  output logic [PIN_W-1:0]  irq_mask,
  output logic [PIN_W-1:0]  irq_type,
  output logic [PIN_W-1:0]  irq_pol,
  output logic [PIN_W-1:0]  irq_both,
  output logic [PIN_W-1:0]  dbc_en,
  output logic [PIN_W-1:0]  dbc_div_en,
  output logic [DIV_W-1:0]  dbc_div,
  output logic [PIN_W-1:0]  eoi_pulse
);
  localparam int HALF_W = PIN_W / 2;
  localparam int IDX_W  = ADDR_W - 3;

  logic                          srst_n;
  logic [IDX_W-1:0]              sel;
  logic                          hi;
  logic [NUM_CFG-1:0][PIN_W-1:0] cfg_q;
  logic [DIV_W-1:0]              div_d, div_q;
  logic                          div_we;
  logic [PIN_W-1:0]              eoi_d, eoi_q;
  logic [HALF_W-1:0]             eoi_bits;
  logic [PIN_W-1:0]              rd_word, rdata_d, rdata_q;

  gpio_wm_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  assign sel = bus_addr[ADDR_W-1:3];
  assign hi  = bus_addr[2];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic hit;
    assign hit = bus_wr && (sel == IDX_W'(g));
    gpio_wm_masked_reg #(.HALF_W(HALF_W)) u_reg (
      .clk   (clk),
      .rst_n (srst_n),
      .wr_lo (hit && !hi),
      .wr_hi (hit && hi),
      .wdata (bus_wdata),
      .q     (cfg_q[g])
    );
  end

  assign out_val    = cfg_q[IDX_DOUT];
  assign out_dir    = cfg_q[IDX_DIR];
  assign irq_en     = cfg_q[IDX_IEN];
  assign irq_mask   = cfg_q[IDX_IMSK];
  assign irq_type   = cfg_q[IDX_ITYP];
  assign irq_pol    = cfg_q[IDX_IPOL];
  assign irq_both   = cfg_q[IDX_IBOTH];
  assign dbc_en     = cfg_q[IDX_DBEN];
  assign dbc_div_en = cfg_q[IDX_DBDEN];

  // Divider: plain, unmasked, low word only
  assign div_we = bus_wr && (sel == IDX_W'(IDX_DIV)) && !hi;
  assign div_d  = bus_wdata[DIV_W-1:0];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     div_q <= '0;
    else if (div_we) div_q <= div_d;
  end
  assign dbc_div = div_q;

  // End-of-interrupt acknowledge
  assign eoi_bits = bus_wdata[HALF_W-1:0] & bus_wdata[PIN_W-1:HALF_W];

  always_comb begin
    eoi_d = '0;
    if (bus_wr && (sel == IDX_W'(IDX_EOI))) begin
      if (hi) eoi_d[PIN_W-1:HALF_W] = eoi_bits;
      else    eoi_d[HALF_W-1:0]     = eoi_bits;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) eoi_q <= '0;
    else         eoi_q <= eoi_d;
  end
  assign eoi_pulse = eoi_q;

  // Read path
  gpio_wm_rd_mux #(.PIN_W(PIN_W), .DIV_W(DIV_W), .IDX_W(IDX_W)) u_rd (
    .sel  (sel),
    .hi   (hi),
    .cfg  (cfg_q),
    .div  (div_q),
    .stat (irq_status_in),
    .raw  (irq_raw_in),
    .pins (pin_in),
    .word (rd_word)
  );

  assign rdata_d = bus_rd ? rd_word : rdata_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end
  assign bus_rdata = rdata_q;

  // R6: version low word
  assert_ver_lo_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && sel == IDX_W'(IDX_VER) && !hi) |=> (bus_rdata == 32'h0000_0C2B));
  // R4: masked and live registers return zero in the upper half
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && sel != IDX_W'(IDX_DIV)) |=> (bus_rdata[PIN_W-1:HALF_W] == '0));
  // R7: status reads reflect the live input
  assert_stat_live_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && sel == IDX_W'(IDX_STAT) && !hi) |=>
      (bus_rdata == {{HALF_W{1'b0}}, $past(irq_status_in[HALF_W-1:0])}));
  // R8: acknowledge pulse only follows a write to the end-of-interrupt word
  assert_eoi_src_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (eoi_pulse != '0) |-> $past(bus_wr && sel == IDX_W'(IDX_EOI)));
  // R5: divider write loads the raw low bits
  assert_div_load_R5: assert property (@(posedge clk) disable iff (!srst_n)
    div_we |=> (dbc_div == $past(bus_wdata[DIV_W-1:0])));
endmodule

// File: tb/gpio_wm_regs_tb.sv
module gpio_wm_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] irq_status_in, irq_raw_in, pin_in;
  logic [31:0] out_val, out_dir, irq_en, irq_mask, irq_type, irq_pol, irq_both;
  logic [31:0] dbc_en, dbc_div_en, eoi_pulse;
  logic [23:0] dbc_div;

  int n_checks = 0;
  int n_fails  = 0;

  // reference model state
  logic [31:0] m_cfg [9];
  logic [23:0] m_div;
  logic [31:0] m_eoi, m_rd;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk = ~clk;   // 50 MHz

  gpio_wm_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_status_in(irq_status_in), .irq_raw_in(irq_raw_in), .pin_in(pin_in),
    .out_val(out_val), .out_dir(out_dir), .irq_en(irq_en), .irq_mask(irq_mask),
    .irq_type(irq_type), .irq_pol(irq_pol), .irq_both(irq_both),
    .dbc_en(dbc_en), .dbc_div_en(dbc_div_en), .dbc_div(dbc_div),
    .eoi_pulse(eoi_pulse)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // Spec-level read value of an address from the model
  function automatic logic [31:0] model_read(input logic [6:0] a);
    int          r = int'(a[6:3]);
    logic        h = a[2];
    logic [31:0] v = 32'h0;
    if (r < 9)        v = m_cfg[r];
    else if (r == 10) v = irq_status_in;
    else if (r == 11) v = irq_raw_in;
    else if (r == 14) v = pin_in;
    else if (r == 15) v = 32'h0100_0C2B;
    if (r == 9) return h ? 32'h0 : {8'h0, m_div};
    return h ? {16'h0, v[31:16]} : {16'h0, v[15:0]};
  endfunction

  task automatic model_step();
    int r = int'(bus_addr[6:3]);
    int base = bus_addr[2] ? 16 : 0;
    if (bus_rd) m_rd = model_read(bus_addr);
    m_eoi = 32'h0;
    if (bus_wr) begin
      if (r < 9) begin
        for (int b = 0; b < 16; b++)
          if (bus_wdata[16+b]) m_cfg[r][base+b] = bus_wdata[b];
      end else if (r == 9 && base == 0) begin
        m_div = bus_wdata[23:0];
      end else if (r == 12) begin
        for (int b = 0; b < 16; b++)
          m_eoi[base+b] = bus_wdata[b] & bus_wdata[16+b];
      end
    end
  endtask

  task automatic compare_all(input string tag);
    chk("R2", "out_val",    out_val,    m_cfg[0]);
    chk("R2", "out_dir",    out_dir,    m_cfg[1]);
    chk("R2", "irq_en",     irq_en,     m_cfg[2]);
    chk("R2", "irq_mask",   irq_mask,   m_cfg[3]);
    chk("R2", "irq_type",   irq_type,   m_cfg[4]);
    chk("R2", "irq_pol",    irq_pol,    m_cfg[5]);
    chk("R2", "irq_both",   irq_both,   m_cfg[6]);
    chk("R2", "dbc_en",     dbc_en,     m_cfg[7]);
    chk("R2", "dbc_div_en", dbc_div_en, m_cfg[8]);
    chk("R5", "dbc_div",    {8'h0, dbc_div}, {8'h0, m_div});
    chk("R8", "eoi_pulse",  eoi_pulse,  m_eoi);
    chk(tag,  "bus_rdata",  bus_rdata,  m_rd);
  endtask

  task automatic cyc(input string tag, input logic wr, input logic rd,
                     input logic [6:0] a, input logic [31:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 9; i++) m_cfg[i] = 32'h0;
    m_div = '0; m_eoi = '0; m_rd = '0;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    irq_status_in = 32'hDEAD_BEEF; irq_raw_in = 32'h1234_5678; pin_in = 32'hA5A5_0F0F;
    repeat (3) @(negedge clk);
    compare_all("R3");   // R3: everything zero under reset
    rst_n = 1'b1;
    repeat (4) cyc("R3", 0, 0, 7'h00, 32'h0);

    // R1/R2: set low half bits 7:0, then upper half
    cyc("R1", 1, 0, 7'h00, 32'h00FF_00A5);
    chk("R1", "out_val low", out_val, 32'h0000_00A5);
    cyc("R1", 1, 0, 7'h04, 32'h8001_8001);
    chk("R1", "out_val high", out_val, 32'h8001_00A5);
    // R2: clear with enable only, and zero-enable write
    cyc("R2", 1, 0, 7'h00, 32'h0001_0000);
    chk("R2", "clear bit0", out_val, 32'h8001_00A4);
    cyc("R2", 1, 0, 7'h00, 32'h0000_FFFF);
    chk("R2", "no-enable write", out_val, 32'h8001_00A4);
    // direction, with read of same word in same cycle (R4: old value)
    cyc("R1", 1, 0, 7'h08, 32'h0F0F_FFFF);
    cyc("R4", 1, 1, 7'h08, 32'hFFFF_0000);
    chk("R4", "read before write", bus_rdata, 32'h0000_0F0F);
    cyc("R4", 0, 1, 7'h08, 32'h0);
    chk("R4", "read after write", bus_rdata, 32'h0);
    cyc("R4", 0, 1, 7'h04, 32'h0);
    chk("R4", "upper read zero-ext", bus_rdata, 32'h0000_8001);
    // R5: divider plain write, upper word ignored
    cyc("R5", 1, 0, 7'h48, 32'hFFAB_CDEF);
    chk("R5", "divider", {8'h0, dbc_div}, 32'h00AB_CDEF);
    cyc("R9", 1, 0, 7'h4C, 32'hFFFF_FFFF);
    cyc("R5", 0, 1, 7'h48, 32'h0);
    chk("R5", "divider readback", bus_rdata, 32'h00AB_CDEF);
    // R6: version
    cyc("R6", 0, 1, 7'h78, 32'h0);
    chk("R6", "version low", bus_rdata, 32'h0000_0C2B);
    cyc("R6", 0, 1, 7'h7C, 32'h0);
    chk("R6", "version high", bus_rdata, 32'h0000_0100);
    // R7: read-only writes ignored, live values read
    cyc("R7", 1, 0, 7'h50, 32'hFFFF_FFFF);
    cyc("R7", 1, 0, 7'h70, 32'hFFFF_FFFF);
    cyc("R7", 1, 0, 7'h78, 32'hFFFF_FFFF);
    cyc("R7", 0, 1, 7'h54, 32'h0);
    chk("R7", "status high", bus_rdata, 32'h0000_DEAD);
    cyc("R7", 0, 1, 7'h58, 32'h0);
    chk("R7", "raw low", bus_rdata, 32'h0000_5678);
    cyc("R7", 0, 1, 7'h74, 32'h0);
    chk("R7", "pins high", bus_rdata, 32'h0000_A5A5);
    // R8: end-of-interrupt pulse
    cyc("R8", 1, 0, 7'h64, 32'h00F0_0FF0);
    chk("R8", "eoi upper", eoi_pulse, 32'h00F0_0000);
    cyc("R8", 0, 1, 7'h60, 32'h0);
    chk("R8", "eoi gone/read zero", eoi_pulse | bus_rdata, 32'h0);
    // R9: unmapped
    cyc("R9", 1, 0, 7'h68, 32'hFFFF_FFFF);
    cyc("R9", 0, 1, 7'h6C, 32'h0);
    chk("R9", "unmapped read", bus_rdata, 32'h0);

    // Random traffic over the whole map, compared every cycle
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, d;
      lfsr = next_rand(lfsr); a = lfsr;
      lfsr = next_rand(lfsr); d = lfsr;
      pin_in = d ^ 32'h5A5A_5A5A; irq_status_in = ~d; irq_raw_in = a;
      cyc("R2", a[8], a[9], {a[4:0], a[11:10]}, d);
    end
    summary();
  end
endmodule